// File: doc/BRIEF.md
# Conversion output gating controller

This block drives the digital output port of a pipelined converter. The pipeline delivers one corrected code, with a valid flag, per clock. The block then decides when that code is placed on the output register, when a conversion-done strobe is raised, and whether the output can be trusted. A conversion enable level controls both the output and the strobe. When the enable drops, the output freezes on the next clock edge. When it rises again, nothing new appears until the full three-clock pipeline delay has passed, so no stale sample leaks out.

A low-bias (standby) level runs beside the enable. While it is high the strobe keeps running from the enable alone, but the data is not to be relied on. When it returns low, the analog circuits need about a microsecond to settle. This wait is modelled as a parameterised count of clock edges, and a trusted flag stays low until the count runs out. Reset starts the block in that settling state.

Top module: `conv_out_gate`

## Requirements
- R1: During and directly after reset, `code_out` is 0, `conv_done` is 0 and `trusted` is 0. Reset also loads the settling count with `REC_CYCLES`.
- R2: `conv_en`, `low_bias`, `code_in` and `code_valid` are sampled on the rising clock edge. The code sampled at edge k is driven on `code_out`, with `conv_done` high, right after edge k+3, provided `conv_en` was sampled high at each of the edges k through k+3.
- R3: At any edge where `conv_en` is sampled low, `conv_done` goes low and `code_out` keeps its value from that edge on. There is no pipeline delay on this path.
- R4: After any edge where `conv_en` was sampled low, `conv_done` stays low for the first three edges with `conv_en` high. It rises only at the fourth such edge, which delivers the sample taken at the first of them.
- R5: `conv_done` depends on `conv_en` only; `low_bias` has no effect on it.
- R6: After any edge where `low_bias` is sampled high, `trusted` is 0.
- R7: After `low_bias` is sampled low again, `trusted` can return high only at the `REC_CYCLES`-th consecutive edge with `low_bias` low.
- R8: With the settling count done, `trusted` is 0 from the first edge of a restart until `conv_done` first rises. It is 1 while `conv_en` is low and the held code is shown.
- R9: A slot whose sample had `code_valid` low still raises `conv_done`, but it leaves `code_out` unchanged.
- R10: `code_out` changes only in cycles where `conv_done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_en | input | 1 | Conversion enable level |
| low_bias | input | 1 | Standby (reduced bias) level |
| code_in | input | W | Corrected code for the sample taken this cycle |
| code_valid | input | 1 | Flag that `code_in` is a usable code |
| code_out | output | W | Registered output code |
| conv_done | output | 1 | Conversion-done strobe, high in each cycle that carries a fresh slot |
| trusted | output | 1 | High when `code_out` can be relied on |

## Verification
The in-module assertions check on every cycle that:
- a low enable freezes the output and clears the strobe on the next edge;
- the strobe never rises before the enable has been sampled high for more than the pipeline depth;
- the output code never moves without the strobe;
- standby and the first cycle of a restart always drop the trusted flag.

Only the bench scenarios can show the exact three-edge alignment of each code with its sample, and that invalid slots leave the code alone. They also show that the strobe keeps running through standby, and that the trusted flag comes back at exactly the `REC_CYCLES`-th edge. The bench compares all three outputs against a queue-based model on every clock.

// File: rtl/conv_out_gate.sv
module conv_out_gate #(
  parameter int W          = 10,
  parameter int LAT        = 3,
  parameter int REC_CYCLES = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_en,
  input  logic         low_bias,
  input  logic [W-1:0] code_in,
  input  logic         code_valid,
  output logic [W-1:0] code_out,
  output logic         conv_done,
  output logic         trusted
);
  localparam int CW = $clog2(REC_CYCLES + 1);
  localparam int RW = $clog2(LAT + 2);

  logic [W-1:0]   stage_q [LAT];
  logic [LAT-1:0] live_q;
  logic [LAT-1:0] good_q;
  logic           run_q;
  logic [CW-1:0]  settle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) stage_q[i] <= '0;
      live_q    <= '0;
      good_q    <= '0;
      run_q     <= 1'b0;
      code_out  <= '0;
      conv_done <= 1'b0;
    end else begin
      run_q <= conv_en;
      if (conv_en) begin
        stage_q[0] <= code_in;
        for (int i = 1; i < LAT; i++) stage_q[i] <= stage_q[i-1];
        live_q    <= (live_q << 1) | LAT'(1);
        good_q    <= (good_q << 1) | LAT'(code_valid);
        conv_done <= live_q[LAT-1];
        if (live_q[LAT-1] && good_q[LAT-1]) code_out <= stage_q[LAT-1];
      end else begin
        live_q    <= '0;
        conv_done <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              settle_q <= CW'(REC_CYCLES);
    else if (low_bias)       settle_q <= CW'(REC_CYCLES);
    else if (settle_q != '0) settle_q <= settle_q - 1'b1;
  end

  assign trusted = (settle_q == '0) && (!run_q || conv_done);

  // run-length tracker used only by the checks below
  logic [RW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= '0;
    else if (!conv_en) run_len <= '0;
    else if (run_len <= RW'(LAT)) run_len <= run_len + 1'b1;
  end

  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> (!conv_done && $stable(code_out)));

  assert_fill_before_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (run_len > RW'(LAT)));

  assert_move_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_out) |-> conv_done);

  assert_bias_distrust_R6: assert property (@(posedge clk) disable iff (!rst_n)
    low_bias |=> !trusted);

  assert_restart_distrust_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && !run_q) |=> !trusted);
endmodule

// File: tb/conv_out_gate_tb.sv
module conv_out_gate_tb_top;
  localparam int W = 10;
  localparam int LAT = 3;
  localparam int REC = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_en = 1'b0, low_bias = 1'b0, code_valid = 1'b0;
  logic [W-1:0] code_in = '0;
  logic [W-1:0] code_out;
  logic conv_done, trusted;

  always #10 clk = ~clk;

  conv_out_gate #(.W(W), .LAT(LAT), .REC_CYCLES(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .low_bias(low_bias),
    .code_in(code_in), .code_valid(code_valid),
    .code_out(code_out), .conv_done(conv_done), .trusted(trusted));

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [W:0] q[$];
  int settle;
  bit m_done, m_run;
  logic [W-1:0] m_out, prev_out;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    q.delete();
    settle = REC; m_done = 0; m_run = 0; m_out = '0; prev_out = '0;
  endtask

  task automatic step(input bit en, input bit bias, input logic [W-1:0] c, input bit v);
    logic [W:0] e;
    conv_en = en; low_bias = bias; code_in = c; code_valid = v;
    @(posedge clk);
    m_run = en;
    if (en) begin
      q.push_back({v, c});
      if (q.size() > LAT) begin
        e = q.pop_front();
        m_done = 1;
        if (e[W]) m_out = e[W-1:0];
      end else m_done = 0;
    end else begin
      q.delete();
      m_done = 0;
    end
    if (bias) settle = REC;
    else if (settle > 0) settle--;
    #5;
    check(code_out === m_out, "R2", "code_out", code_out, m_out);
    check(conv_done === m_done, "R4", "conv_done", conv_done, m_done);
    check(trusted === (settle == 0 && (!m_run || m_done)), "R8", "trusted",
          trusted, (settle == 0 && (!m_run || m_done)));
    check(code_out === prev_out || conv_done, "R10", "code_out moved without strobe",
          code_out, prev_out);
    prev_out = code_out;
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [W-1:0] held;
    model_reset();
    repeat (3) @(posedge clk);
    #5;
    check(code_out === '0 && conv_done === 1'b0 && trusted === 1'b0, "R1",
          "reset state", {code_out, conv_done, trusted}, 0);
    rst_n = 1'b1;

    // R7: settle after reset, enable low
    cnt = 0;
    for (int i = 1; i <= REC + 2; i++) begin
      step(0, 0, '0, 0);
      if (trusted && cnt == 0) cnt = i;
    end
    check(cnt == REC, "R7", "edges to trusted after reset", cnt, REC);

    // R2 steady run with varying codes
    for (int i = 0; i < 40; i++) step(1, 0, W'($urandom), 1);

    // R3 freeze: output held for many cycles
    held = code_out;
    for (int i = 0; i < 12; i++) step(0, 0, W'($urandom), 1);
    check(code_out === held && !conv_done, "R3", "frozen output", code_out, held);

    // R4 restart: strobe at fourth edge
    cnt = 0;
    for (int i = 1; i <= 6; i++) begin
      step(1, 0, W'(100 + i), 1);
      if (conv_done && cnt == 0) cnt = i;
    end
    check(cnt == LAT + 1, "R4", "edge of first strobe after restart", cnt, LAT + 1);
    check(code_out === W'(101 + (6 - (LAT + 1))) , "R2", "aligned code", code_out, 101 + 6 - (LAT + 1));

    // one-cycle enable drop
    step(0, 0, 10'h3FF, 1);
    for (int i = 0; i < 8; i++) step(1, 0, W'($urandom), 1);

    // R9 invalid slot keeps code
    for (int i = 0; i < 6; i++) step(1, 0, W'(200 + i), 1);
    step(1, 0, 10'h155, 0);
    for (int i = 0; i < LAT - 1; i++) step(1, 0, W'(300 + i), 1);
    held = code_out;
    step(1, 0, 10'h0AA, 1);
    check(conv_done && code_out === held, "R9", "invalid slot changed code", code_out, held);
    for (int i = 0; i < 6; i++) step(1, 0, W'($urandom), $urandom_range(0, 1));

    // R5/R6: standby with enable high
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      step(1, 1, W'($urandom), 1);
      if (conv_done) cnt++;
      check(!trusted, "R6", "trusted during standby", trusted, 0);
    end
    check(cnt == 10, "R5", "strobes during standby", cnt, 10);

    // R7 recovery with enable running
    cnt = 0;
    for (int i = 1; i <= REC + 3; i++) begin
      step(1, 0, W'($urandom), 1);
      if (trusted && cnt == 0) cnt = i;
    end
    check(cnt == REC, "R7", "edges to trusted after standby", cnt, REC);

    // mixed pattern
    for (int i = 0; i < 200; i++)
      step($urandom_range(0, 5) != 0, $urandom_range(0, 30) == 0,
           W'($urandom), $urandom_range(0, 7) != 0);

    // brief reset mid-run
    rst_n = 1'b0;
    #5;
    check(code_out === '0 && !conv_done && !trusted, "R1", "async reset",
          {code_out, conv_done, trusted}, 0);
    model_reset();
    @(posedge clk); #5;
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) step(1, 0, W'($urandom), 1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule